// File: doc/BRIEF.md
# Dual-Clock Programmable Fill-Level Flags

This block watches how many words sit in a dual-clock FIFO of depth `DEPTH` and raises two early-warning flags. The writer side sees an active-low near-full flag, and the reader side sees an active-low near-empty flag. Each flag is evaluated in its own clock domain. The writer's pointer reaches the reader through a two-flop synchronized Gray code, and the reader's pointer reaches the writer the same way. Each side therefore sees its own actions at once and the other side's actions two of its own rising edges later.

The near-full threshold is the depth minus a full-side offset. The near-empty threshold is an empty-side offset. Both offsets are captured, limited to a legal range, while their domain is held in reset. A word that the reader has taken into its output register counts as already gone from the memory.

The writer may feed the memory in narrower beats. A mode input selects one, two or four beats per stored word. Only the beat that completes a word moves the level.

Top module: `fifo_level_flags`

## Requirements
- R1: While reset is held, each domain drives `af_n` HIGH and `ae_n` LOW, and both domains start with a fill level of zero.
- R2: `af_n` is LOW whenever the writer-side level is at least `DEPTH - Y`, and HIGH whenever it is at most `DEPTH - Y - 1`. A committed word is counted right after the write-clock edge that takes it.
- R3: A read reaches `af_n` after two write-clock rising edges. A `rd_take` sampled at edge E is first seen by the write side just after edge E+2.
- R4: `ae_n` is LOW whenever the reader-side level is at most `X`, and HIGH whenever it is at least `X + 1`. A take counts as a read at the very read-clock edge that samples `rd_take`, because the word is then in the output register.
- R5: A committed write reaches `ae_n` after two read-clock rising edges. A word committed at edge E is first seen by the read side just after edge E+2.
- R6: `wr_mode` sets the beats per word. 2'b00 selects one beat, 2'b01 selects two beats, and 2'b10 and 2'b11 both select four beats. Only the final beat of a word changes either level.
- R7: `full_off` (Y) and `empty_off` (X) are sampled on clock edges of their own domain while that domain is in reset. Each captured value is limited to the range 1 to `DEPTH - 4`: 0 becomes 1, and anything above `DEPTH - 4` becomes `DEPTH - 4`.
- R8: A change to `full_off` or `empty_off` outside reset has no effect on either threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_mode | input | 2 | Beats per stored word (see R6) |
| wr_beat | input | 1 | One write beat accepted this cycle |
| full_off | input | OFF_W | Near-full offset Y, captured during reset |
| af_n | output | 1 | Near-full flag, active low, write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_take | input | 1 | One word moved into the output register this cycle |
| empty_off | input | OFF_W | Near-empty offset X, captured during reset |
| ae_n | output | 1 | Near-empty flag, active low, read domain |

## Verification
The assertions assume three things about the inputs. The writer never completes a word while its own view of the level already equals `DEPTH`. The reader never takes a word while its own view is zero. `wr_mode` changes only while the write domain is in reset. The bench's driver keeps its own per-side view of the level, built from the same two-edge lag, and drops any beat or take that would break these limits before the beat or take reaches the pins. It also changes mode only inside reset phases. Both domains run from one clock in the bench, so the two-edge latency is checked cycle by cycle.

// File: rtl/flag_pkg.sv
package flag_pkg;

    typedef enum logic [1:0] {
        BEATS_ONE   = 2'b00,
        BEATS_TWO   = 2'b01,
        BEATS_FOUR  = 2'b10,
        BEATS_FOURX = 2'b11
    } beat_mode_e;

    // number of beats that make one stored word
    function automatic logic [2:0] beats_of(beat_mode_e m);
        case (m)
            BEATS_ONE: return 3'd1;
            BEATS_TWO: return 3'd2;
            default:   return 3'd4;
        endcase
    endfunction

    // limit an offset to [lo, hi]
    function automatic int unsigned clamp_off(int unsigned v, int unsigned lo, int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/flg_beat_gate.sv
module flg_beat_gate
    import flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  beat_mode_e mode,
    input  logic       beat,
    output logic       commit
);
    logic [1:0] beat_q;
    logic [2:0] last_idx;

    always_comb begin
        last_idx = beats_of(mode) - 3'd1;
        commit   = beat && ({1'b0, beat_q} == last_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (beat) begin
            beat_q <= commit ? 2'd0 : beat_q + 2'd1;
        end
    end

    // R6: partial-word position never passes the last beat of the mode
    p_beat_bound_r6: assert property (@(posedge clk) disable iff (rst)
        {1'b0, beat_q} <= last_idx);

endmodule

// File: rtl/flg_ptr.sv
module flg_ptr #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [PW-1:0] bin_o,
    output logic [PW-1:0] gray_o
);
    logic [PW-1:0] bin_nx;

    always_comb bin_nx = bin_o + PW'(inc);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_o  <= '0;
            gray_o <= '0;
        end else begin
            bin_o  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end
    end

endmodule

// File: rtl/flg_sync.sv
module flg_sync #(
    parameter int PW     = 5,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_i,
    output logic [PW-1:0] bin_o
);
    logic [PW-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= gray_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            bin_o[i] = ^(stage_q[STAGES-1] >> i);
        end
    end

    // R3 R5: the synchronized Gray word moves by at most one bit per edge
    p_gray_step_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stage_q[STAGES-1] ^ $past(stage_q[STAGES-1])));

endmodule

// File: rtl/flg_offset_reg.sv
module flg_offset_reg #(
    parameter int          OW = 5,
    parameter int unsigned LO = 1,
    parameter int unsigned HI = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [OW-1:0] off_i,
    output logic [OW-1:0] off_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= OW'(flag_pkg::clamp_off(32'(off_i), LO, HI));
        end
    end

    // R8: captured offset holds once reset is released
    p_off_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(off_q));

    // R7: captured offset is inside the legal window
    p_off_range_r7: assert property (@(posedge clk) disable iff (rst)
        (32'(off_q) >= LO) && (32'(off_q) <= HI));

endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags
    import flag_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int STAGES = 2,
    parameter int OFF_W  = $clog2(DEPTH) + 1
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic [1:0]       wr_mode,
    input  logic             wr_beat,
    input  logic [OFF_W-1:0] full_off,
    output logic             af_n,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_take,
    input  logic [OFF_W-1:0] empty_off,
    output logic             ae_n
);
    localparam int          CW      = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam int unsigned OFF_HI  = DEPTH - 4;

    // ---------------- write domain ----------------
    logic          commit;
    logic [CW-1:0] wbin, wgray, rbin_w, wfill;
    logic [OFF_W-1:0] y_q;

    flg_beat_gate u_gate (
        .clk    (wr_clk),
        .rst    (wr_rst),
        .mode   (beat_mode_e'(wr_mode)),
        .beat   (wr_beat),
        .commit (commit)
    );

    flg_ptr #(.PW(CW)) u_wptr (
        .clk    (wr_clk),
        .rst    (wr_rst),
        .inc    (commit),
        .bin_o  (wbin),
        .gray_o (wgray)
    );

    flg_offset_reg #(.OW(OFF_W), .LO(1), .HI(OFF_HI)) u_yoff (
        .clk   (wr_clk),
        .rst   (wr_rst),
        .off_i (full_off),
        .off_q (y_q)
    );

    // ---------------- read domain ----------------
    logic [CW-1:0] rbin, rgray, wbin_r, rfill;
    logic [OFF_W-1:0] x_q;

    flg_ptr #(.PW(CW)) u_rptr (
        .clk    (rd_clk),
        .rst    (rd_rst),
        .inc    (rd_take),
        .bin_o  (rbin),
        .gray_o (rgray)
    );

    flg_offset_reg #(.OW(OFF_W), .LO(1), .HI(OFF_HI)) u_xoff (
        .clk   (rd_clk),
        .rst   (rd_rst),
        .off_i (empty_off),
        .off_q (x_q)
    );

    // ---------------- crossings ----------------
    flg_sync #(.PW(CW), .STAGES(STAGES)) u_r2w (
        .clk    (wr_clk),
        .rst    (wr_rst),
        .gray_i (rgray),
        .bin_o  (rbin_w)
    );

    flg_sync #(.PW(CW), .STAGES(STAGES)) u_w2r (
        .clk    (rd_clk),
        .rst    (rd_rst),
        .gray_i (wgray),
        .bin_o  (wbin_r)
    );

    // ---------------- flag compare ----------------
    always_comb begin
        wfill = wbin - rbin_w;
        rfill = wbin_r - rbin;
        af_n  = !(wfill >= (DEPTH_C - CW'(y_q)));
        ae_n  = (rfill > CW'(x_q));
    end

    // R2: writer-side level never exceeds the depth
    p_wfill_max_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wfill <= DEPTH_C);

    // R4: reader-side level never exceeds the depth
    p_rfill_max_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rfill <= DEPTH_C);

    // R2: near-full can only assert after a local word commit
    p_af_fall_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $fell(af_n) |-> $past(commit));

    // R3: near-full can only release when the synced read pointer moves
    p_af_rise_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $rose(af_n) |-> !$stable(rbin_w));

    // R4: near-empty can only assert after a local take
    p_ae_fall_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $fell(ae_n) |-> $past(rd_take));

    // R5: near-empty can only release when the synced write pointer moves
    p_ae_rise_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $rose(ae_n) |-> !$stable(wbin_r));

endmodule

// File: tb/fifo_level_flags_tb_top.sv
`timescale 1ns/1ps
module fifo_level_flags_tb_top;
    localparam int D  = 16;
    localparam int OW = $clog2(D) + 1;

    typedef struct {
        bit    af_n;
        bit    ae_n;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'b00;
    logic          beat = 1'b0;
    logic          take = 1'b0;
    logic [OW-1:0] yin = OW'(3);
    logic [OW-1:0] xin = OW'(2);
    logic          af_n, ae_n;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    // bench model
    int W, R, bcnt, beats, ym, xm;
    int wh[3];
    int rh[3];

    always #10 clk = ~clk;

    fifo_level_flags #(.DEPTH(D)) dut_i (
        .wr_clk    (clk),
        .wr_rst    (rst),
        .wr_mode   (mode),
        .wr_beat   (beat),
        .full_off  (yin),
        .af_n      (af_n),
        .rd_clk    (clk),
        .rd_rst    (rst),
        .rd_take   (take),
        .empty_off (xin),
        .ae_n      (ae_n)
    );

    function automatic int clampi(int v);
        if (v < 1) return 1;
        if (v > D - 4) return D - 4;
        return v;
    endfunction

    function automatic int beats_for(logic [1:0] m);
        case (m)
            2'b00:   return 1;
            2'b01:   return 2;
            default: return 4;
        endcase
    endfunction

    task automatic check(string tag, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // monitor: samples mid-cycle after the edge the entry belongs to
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "af_n", af_n, e.af_n);
            check(e.tag, "ae_n", ae_n, e.ae_n);
        end
    end

    // R1 R7: one cycle of reset with given mode and offsets
    task automatic rst_step(logic [1:0] m, int y, int x);
        exp_t e;
        @(negedge clk);
        rst = 1'b1; beat = 1'b0; take = 1'b0;
        mode = m; yin = OW'(y); xin = OW'(x);
        W = 0; R = 0; bcnt = 0;
        for (int i = 0; i < 3; i++) begin wh[i] = 0; rh[i] = 0; end
        beats = beats_for(m); ym = clampi(y); xm = clampi(x);
        e.af_n = 1'b1; e.ae_n = 1'b0; e.tag = "R1";
        q.push_back(e);
    endtask

    // driver: one cycle of beats/takes, gated to stay legal
    task automatic step(bit b, bit t, string tag);
        exp_t e;
        bit fin;
        @(negedge clk);
        rst = 1'b0;
        fin = b && (bcnt + 1 == beats);
        if (fin && (W + 1 - rh[1] > D)) begin b = 1'b0; fin = 1'b0; end
        if (t && (wh[1] - R < 1)) t = 1'b0;
        beat = b; take = t;
        if (b) begin
            bcnt++;
            if (fin) begin W++; bcnt = 0; end
        end
        if (t) R++;
        wh[2] = wh[1]; wh[1] = wh[0]; wh[0] = W;
        rh[2] = rh[1]; rh[1] = rh[0]; rh[0] = R;
        e.af_n = !((W - rh[2]) >= (D - ym));
        e.ae_n = ((wh[2] - R) > xm);
        e.tag  = tag;
        q.push_back(e);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // phase A: one beat per word, Y=3, X=2
        repeat (3) rst_step(2'b00, 3, 2);
        repeat (18) step(1, 0, "R2,R5 fill");
        repeat (3)  step(0, 0, "R2 hold");
        repeat (18) step(0, 1, "R3,R4 drain");
        repeat (8)  step(1, 0, "R2,R5 refill");
        repeat (10) step(1, 1, "R3,R4 mixed");
        repeat (3)  step(0, 0, "R4 hold");
        repeat (20) step(0, 1, "R3,R4 drain2");

        // phase B: two beats per word, offsets clamped, then input changes ignored
        repeat (2) rst_step(2'b01, 0, 31);
        @(negedge clk);
        yin = OW'(8); xin = OW'(1);
        rst = 1'b0;
        q.push_back('{af_n: 1'b1, ae_n: 1'b0, tag: "R8 idle"});
        repeat (36) step(1, 0, "R6,R7,R8 fill");
        repeat (3)  step(0, 0, "R7 hold");
        repeat (18) step(0, 1, "R7,R8 drain");

        // phase C: four beats per word via code 2'b11, Y=5, X=4
        repeat (2) rst_step(2'b11, 5, 4);
        for (int i = 0; i < 70; i++) step(1, (i % 6) == 5, "R6 quad");
        repeat (3)  step(0, 0, "R6 hold");
        repeat (20) step(0, 1, "R6 drain");

        repeat (3) step(0, 0, "R1 tail");
        @(negedge clk);
        beat = 1'b0; take = 1'b0;
        repeat (2) @(posedge clk);
        #7;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule